// File: doc/BRIEF.md
# Memory-Mapped RAM and I/O Controller

This block connects a simple processor load/store unit to a dual-port synchronous RAM of 4 KB and to two small peripherals. Each request is a load or a store of a byte, halfword or word at any byte address. The RAM is organised as 32-bit words. An access that straddles two words is served in one transaction: port A always carries the lower word and port B the word after it. So no access ever needs a second cycle.

The address is decoded into three regions. A window starting at 0x4000_0000 and ending at 0x4AFF_FFFF is a write-only path to a video framebuffer: a store there produces one pixel write. The single address 0x4B00_0000 reads the state of four push buttons. Every other address lands in RAM, and the offset wraps modulo the memory size. A load issued in one cycle delivers its aligned, sign- or zero-extended result on the next cycle, once the RAM read data has arrived.

Top module: `memio_ctrl`

## Requirements
- R1: RAM port A addresses word `addr[11:2]`. Port B addresses the following word, modulo 1024. Port B is enabled only when the access runs past the end of port A's word; port A is enabled for every RAM access.
- R2: The size code `req_size` is 0 for a byte, 1 for a halfword, and 2 or 3 for a word. A RAM store enables exactly the byte lanes the access covers, on the port whose word holds each byte. Byte k of `req_wdata` goes to absolute byte `addr+k`, where lane j of a word is bits 8j+7:8j.
- R3: A load issued in cycle n raises `rsp_valid` in cycle n+1, with the data merged from both ports. When no load was issued in the previous cycle, `rsp_valid` is 0.
- R4: A byte or halfword load with `req_unsigned`=0 is sign-extended to 32 bits; with `req_unsigned`=1 it is zero-extended.
- R5: A store to 0x4000_0000..0x4AFF_FFFF pulses `fb_we`, with `fb_index` = addr − 0x4000_0000 and `fb_data` = `req_wdata[7:0]`. No RAM byte lane is enabled.
- R6: A framebuffer store whose index is 76800 or more writes nothing: `fb_we` stays 0 and RAM is untouched.
- R7: A load from the framebuffer window returns 0.
- R8: A load from 0x4B00_0000 returns the buttons, as sampled in the issue cycle, in bits 3:0 with all other bits zero.
- R9: A store to 0x4B00_0000 changes neither RAM nor the framebuffer.
- R10: During and right after reset, `rsp_valid` is 0. With `req_valid` low, no RAM lane and no framebuffer write is enabled.
- R11: A RAM-region address at or above 4096 reaches the same bytes as its value modulo 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_unsigned | input | 1 | Zero-extend narrow loads |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | Load result valid |
| rsp_rdata | output | 32 | Load result |
| ram_a_en | output | 1 | Port A enable (lower word) |
| ram_a_addr | output | 10 | Port A word index |
| ram_a_we | output | 4 | Port A byte-lane write enables |
| ram_a_wdata | output | 32 | Port A write data |
| ram_a_rdata | input | 32 | Port A read data, one cycle after enable |
| ram_b_en | output | 1 | Port B enable (upper word) |
| ram_b_addr | output | 10 | Port B word index |
| ram_b_we | output | 4 | Port B byte-lane write enables |
| ram_b_wdata | output | 32 | Port B write data |
| ram_b_rdata | input | 32 | Port B read data, one cycle after enable |
| fb_we | output | 1 | Framebuffer pixel write strobe |
| fb_index | output | 17 | Pixel index |
| fb_data | output | 8 | Pixel value |
| btn_in | input | 4 | Push-button state |

## Verification
The assertions assume that the RAM behind the ports returns, one cycle after an enable, the word at the address presented, and that no load and store touch the same word in the same cycle. The bench meets this with a behavioural dual-port RAM that reads the old contents and applies byte-lane writes. It issues at most one request at a time, so the two ports never address the same word. The assertions also assume that `req_size` and `req_unsigned` are meaningful only while `req_valid` is high, and the bench holds every request field steady across the single clock edge that captures it.

// File: rtl/memio_pkg.sv
package memio_pkg;

    localparam logic [31:0] FB_FIRST = 32'h4000_0000;
    localparam logic [31:0] FB_FINAL = 32'h4AFF_FFFF;
    localparam logic [31:0] BTN_ADR  = 32'h4B00_0000;
    localparam int          BTN_W    = 4;

    typedef enum logic [1:0] {
        RGN_RAM = 2'd0,
        RGN_FB  = 2'd1,
        RGN_BTN = 2'd2
    } region_e;

    typedef struct packed {
        region_e            region;
        logic [1:0]         off;
        logic [1:0]         size;
        logic               uns;
        logic [BTN_W-1:0]   btn;
    } ld_ctx_t;

    // Byte count for a size code: 0 -> 1, 1 -> 2, otherwise 4.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Lane mask over the two-word window {upper, lower}.
    function automatic logic [7:0] lane_mask(input logic [1:0] off, input logic [1:0] sz);
        logic [7:0] base;
        case (sz)
            2'd0:    base = 8'b0000_0001;
            2'd1:    base = 8'b0000_0011;
            default: base = 8'b0000_1111;
        endcase
        return base << off;
    endfunction

endpackage

// File: rtl/memio_decode.sv
module memio_decode
    import memio_pkg::*;
#(
    parameter int FB_PIXELS = 76800,
    parameter int FB_IDX_W  = 17
) (
    input  logic [31:0]         addr,
    output region_e             region,
    output logic                fb_ok,
    output logic [FB_IDX_W-1:0] fb_index
);
    logic [31:0] fb_off;

    always_comb begin
        if (addr >= FB_FIRST && addr <= FB_FINAL)
            region = RGN_FB;
        else if (addr == BTN_ADR)
            region = RGN_BTN;
        else
            region = RGN_RAM;
    end

    assign fb_off   = addr - FB_FIRST;
    assign fb_ok    = (fb_off < 32'(FB_PIXELS));
    assign fb_index = fb_off[FB_IDX_W-1:0];

endmodule

// File: rtl/memio_lanes.sv
module memio_lanes
    import memio_pkg::*;
#(
    parameter int WORD_AW = 10
) (
    input  logic               go,
    input  logic               write,
    input  logic [1:0]         size,
    input  logic [WORD_AW+1:0] baddr,
    input  logic [31:0]        wdata,
    output logic [1:0]         port_en,
    output logic [WORD_AW-1:0] port_addr [2],
    output logic [3:0]         port_we   [2],
    output logic [31:0]        port_wdata[2]
);
    logic [7:0]         mask;
    logic [63:0]        wide;
    logic [WORD_AW-1:0] base_word;

    assign mask      = lane_mask(baddr[1:0], size);
    assign wide      = {32'd0, wdata} << {baddr[1:0], 3'b000};
    assign base_word = baddr[WORD_AW+1:2];

    for (genvar p = 0; p < 2; p++) begin : g_port
        logic [3:0] slice;
        assign slice         = mask[4*p +: 4];
        assign port_en[p]    = go && (slice != 4'd0);
        assign port_addr[p]  = base_word + WORD_AW'(p);
        assign port_we[p]    = (go && write) ? slice : 4'd0;
        assign port_wdata[p] = wide[32*p +: 32];
    end

endmodule

// File: rtl/memio_ldmerge.sv
module memio_ldmerge
    import memio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        issue,
    input  ld_ctx_t     ctx_in,
    input  logic [31:0] lo_rdata,
    input  logic [31:0] hi_rdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);
    ld_ctx_t     ctx_q;
    logic        vld_q;
    logic [31:0] aligned;
    logic [31:0] ram_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            ctx_q <= '0;
        end else begin
            vld_q <= issue;
            if (issue) ctx_q <= ctx_in;
        end
    end

    assign aligned = 32'({hi_rdata, lo_rdata} >> {ctx_q.off, 3'b000});

    always_comb begin
        case (ctx_q.size)
            2'd0:    ram_val = ctx_q.uns ? {24'd0, aligned[7:0]}
                                         : {{24{aligned[7]}}, aligned[7:0]};
            2'd1:    ram_val = ctx_q.uns ? {16'd0, aligned[15:0]}
                                         : {{16{aligned[15]}}, aligned[15:0]};
            default: ram_val = aligned;
        endcase
        rsp_rdata = '0;
        if (vld_q) begin
            case (ctx_q.region)
                RGN_RAM: rsp_rdata = ram_val;
                RGN_BTN: rsp_rdata = {{(32-BTN_W){1'b0}}, ctx_q.btn};
                default: rsp_rdata = '0;
            endcase
        end
    end

    assign rsp_valid = vld_q;

endmodule

// File: rtl/memio_ctrl.sv
module memio_ctrl
    import memio_pkg::*;
#(
    parameter int MEM_BYTES = 4096,
    parameter int FB_PIXELS = 76800,
    localparam int WORD_AW  = $clog2(MEM_BYTES / 4),
    localparam int FB_IDX_W = $clog2(FB_PIXELS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic                req_unsigned,
    input  logic [31:0]         req_addr,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata,
    output logic                ram_a_en,
    output logic [WORD_AW-1:0]  ram_a_addr,
    output logic [3:0]          ram_a_we,
    output logic [31:0]         ram_a_wdata,
    input  logic [31:0]         ram_a_rdata,
    output logic                ram_b_en,
    output logic [WORD_AW-1:0]  ram_b_addr,
    output logic [3:0]          ram_b_we,
    output logic [31:0]         ram_b_wdata,
    input  logic [31:0]         ram_b_rdata,
    output logic                fb_we,
    output logic [FB_IDX_W-1:0] fb_index,
    output logic [7:0]          fb_data,
    input  logic [3:0]          btn_in
);
    region_e            region;
    logic               fb_ok;
    logic               ram_go;
    logic [1:0]         p_en;
    logic [WORD_AW-1:0] p_addr [2];
    logic [3:0]         p_we   [2];
    logic [31:0]        p_wd   [2];
    ld_ctx_t            ctx;

    memio_decode #(.FB_PIXELS(FB_PIXELS), .FB_IDX_W(FB_IDX_W)) u_decode (
        .addr     (req_addr),
        .region   (region),
        .fb_ok    (fb_ok),
        .fb_index (fb_index)
    );

    assign ram_go = req_valid && (region == RGN_RAM);

    memio_lanes #(.WORD_AW(WORD_AW)) u_lanes (
        .go         (ram_go),
        .write      (req_write),
        .size       (req_size),
        .baddr      (req_addr[WORD_AW+1:0]),
        .wdata      (req_wdata),
        .port_en    (p_en),
        .port_addr  (p_addr),
        .port_we    (p_we),
        .port_wdata (p_wd)
    );

    assign ram_a_en    = p_en[0];
    assign ram_a_addr  = p_addr[0];
    assign ram_a_we    = p_we[0];
    assign ram_a_wdata = p_wd[0];
    assign ram_b_en    = p_en[1];
    assign ram_b_addr  = p_addr[1];
    assign ram_b_we    = p_we[1];
    assign ram_b_wdata = p_wd[1];

    assign fb_we   = req_valid && req_write && (region == RGN_FB) && fb_ok;
    assign fb_data = req_wdata[7:0];

    assign ctx = '{region: region, off: req_addr[1:0], size: req_size,
                   uns: req_unsigned, btn: btn_in};

    memio_ldmerge u_ldmerge (
        .clk       (clk),
        .rst       (rst),
        .issue     (req_valid && !req_write),
        .ctx_in    (ctx),
        .lo_rdata  (ram_a_rdata),
        .hi_rdata  (ram_b_rdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // R1
    upper_needs_lower_chk: assert property (@(posedge clk) disable iff (rst)
        ram_b_en |-> ram_a_en);

    // R2
    store_lane_count_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && region == RGN_RAM) |->
        ($countones(ram_a_we) + $countones(ram_b_we) == int'(size_bytes(req_size))));

    // R3
    rsp_follows_load_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    // R5
    fb_excludes_ram_chk: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (ram_a_we == 4'd0 && ram_b_we == 4'd0));

    // R6
    fb_index_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (32'(fb_index) < 32'(FB_PIXELS)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!fb_we && ram_a_we == 4'd0 && ram_b_we == 4'd0));

endmodule

// File: tb/memio_ctrl_tb.sv
`timescale 1ns/1ps
module memio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_unsigned = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        ram_a_en, ram_b_en;
    logic [9:0]  ram_a_addr, ram_b_addr;
    logic [3:0]  ram_a_we, ram_b_we;
    logic [31:0] ram_a_wdata, ram_b_wdata, ram_a_rdata, ram_b_rdata;
    logic        fb_we;
    logic [16:0] fb_index;
    logic [7:0]  fb_data;
    logic [3:0]  btn_in = 4'd0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    memio_ctrl u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_a_en(ram_a_en), .ram_a_addr(ram_a_addr), .ram_a_we(ram_a_we),
        .ram_a_wdata(ram_a_wdata), .ram_a_rdata(ram_a_rdata),
        .ram_b_en(ram_b_en), .ram_b_addr(ram_b_addr), .ram_b_we(ram_b_we),
        .ram_b_wdata(ram_b_wdata), .ram_b_rdata(ram_b_rdata),
        .fb_we(fb_we), .fb_index(fb_index), .fb_data(fb_data), .btn_in(btn_in)
    );

    // Behavioural dual-port RAM, synchronous read of old contents.
    logic [31:0] mem [1024];
    initial for (int i = 0; i < 1024; i++) mem[i] = '0;
    always @(posedge clk) begin
        if (ram_a_en) begin
            ram_a_rdata <= mem[ram_a_addr];
            for (int j = 0; j < 4; j++)
                if (ram_a_we[j]) mem[ram_a_addr][8*j +: 8] <= ram_a_wdata[8*j +: 8];
        end
        if (ram_b_en) begin
            ram_b_rdata <= mem[ram_b_addr];
            for (int j = 0; j < 4; j++)
                if (ram_b_we[j]) mem[ram_b_addr][8*j +: 8] <= ram_b_wdata[8*j +: 8];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [1:0] sz, input logic un,
                         input logic [31:0] ad, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_unsigned = un; req_addr = ad; req_wdata = wd;
        #1;
    endtask

    task automatic retire;
        @(negedge clk);
    endtask

    task automatic idle;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // {write, size, unsigned, addr, wdata, expected}
    localparam int NV = 20;
    localparam logic [99:0] VEC [NV] = '{
        {1'b1, 2'd2, 1'b0, 32'h0000_0000, 32'h4433_2211, 32'h0},
        {1'b1, 2'd2, 1'b0, 32'h0000_0004, 32'h8877_6655, 32'h0},
        {1'b1, 2'd2, 1'b0, 32'h0000_03FC, 32'hDDCC_BBAA, 32'h0},
        {1'b0, 2'd2, 1'b0, 32'h0000_0001, 32'h0,         32'h5544_3322},
        {1'b0, 2'd1, 1'b0, 32'h0000_0003, 32'h0,         32'h0000_5544},
        {1'b0, 2'd0, 1'b0, 32'h0000_0007, 32'h0,         32'hFFFF_FF88},
        {1'b0, 2'd0, 1'b1, 32'h0000_0007, 32'h0,         32'h0000_0088},
        {1'b0, 2'd1, 1'b0, 32'h0000_03FE, 32'h0,         32'hFFFF_DDCC},
        {1'b0, 2'd1, 1'b1, 32'h0000_03FE, 32'h0,         32'h0000_DDCC},
        {1'b1, 2'd1, 1'b0, 32'h0000_0005, 32'h0000_ABCD, 32'h0},
        {1'b0, 2'd2, 1'b0, 32'h0000_0004, 32'h0,         32'h88AB_CD55},
        {1'b1, 2'd2, 1'b0, 32'h0000_000E, 32'hF0E0_D0C0, 32'h0},
        {1'b0, 2'd2, 1'b0, 32'h0000_000C, 32'h0,         32'hD0C0_0000},
        {1'b0, 2'd3, 1'b0, 32'h0000_0010, 32'h0,         32'h0000_F0E0},
        {1'b0, 2'd1, 1'b0, 32'h0000_000F, 32'h0,         32'hFFFF_E0D0},
        {1'b1, 2'd2, 1'b0, 32'h0000_0FFE, 32'h1234_5678, 32'h0},
        {1'b0, 2'd2, 1'b0, 32'h0000_0000, 32'h0,         32'h4433_1234},
        {1'b0, 2'd1, 1'b1, 32'h0000_0FFE, 32'h0,         32'h0000_5678},
        {1'b0, 2'd2, 1'b0, 32'h0000_1000, 32'h0,         32'h4433_1234},
        {1'b0, 2'd0, 1'b0, 32'h0000_2001, 32'h0,         32'h0000_0012}
    };

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R10 rsp_valid in reset", 32'(rsp_valid), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10 rsp_valid after reset", 32'(rsp_valid), 32'h0);
        chk({ram_a_we, ram_b_we, fb_we} == 9'd0, "R10 idle writes", 32'({ram_a_we, ram_b_we, fb_we}), 32'h0);

        // Table walk: R2 stores, R3/R4/R11 loads
        for (int v = 0; v < NV; v++) begin
            logic [99:0] e;
            string tag;
            e = VEC[v];
            drive(e[99], e[98:97], e[96], e[95:64], e[63:32]);
            retire();
            if (!e[99]) begin
                if (e[95:64] >= 32'h1000) tag = "R11 alias load";
                else if (e[98:97] < 2'd2) tag = "R4 narrow load";
                else tag = "R3 R2 word load";
                chk(rsp_valid == 1'b1, "R3 rsp_valid", 32'(rsp_valid), 32'h1);
                chk(rsp_rdata == e[31:0], tag, rsp_rdata, e[31:0]);
            end
            idle();
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R3 no load no rsp", 32'(rsp_valid), 32'h0);

        // R1/R2: port split of a crossing store
        drive(1'b1, 2'd2, 1'b0, 32'h0000_001E, 32'hA1B2_C3D4);
        chk(ram_a_addr == 10'd7 && ram_b_addr == 10'd8, "R1 crossing addrs", {ram_a_addr, 6'd0, ram_b_addr, 6'd0}, {10'd7, 6'd0, 10'd8, 6'd0});
        chk(ram_a_we == 4'b1100 && ram_b_we == 4'b0011, "R2 crossing lanes", {24'd0, ram_a_we, ram_b_we}, 32'h0000_00C3);
        chk(ram_a_wdata[31:16] == 16'hC3D4 && ram_b_wdata[15:0] == 16'hA1B2, "R2 lane data", {ram_a_wdata[31:16], ram_b_wdata[15:0]}, 32'hC3D4_A1B2);
        retire(); idle();
        // R1: wrap of port B and aligned access with B idle
        drive(1'b0, 2'd2, 1'b0, 32'h0000_0FFD, 32'h0);
        chk(ram_a_addr == 10'd1023 && ram_b_addr == 10'd0 && ram_b_en, "R1 upper wraps", {ram_a_addr, 6'd0, ram_b_addr, 5'd0, ram_b_en}, {10'd1023, 6'd0, 10'd0, 5'd0, 1'b1});
        retire(); idle();
        drive(1'b0, 2'd2, 1'b0, 32'h0000_0008, 32'h0);
        chk(ram_a_en && ram_a_addr == 10'd2 && !ram_b_en, "R1 aligned single port", {ram_a_addr, 20'd0, ram_a_en, ram_b_en}, {10'd2, 20'd0, 2'b10});
        retire(); idle();

        // R5: framebuffer store
        drive(1'b1, 2'd2, 1'b0, 32'h4000_0005, 32'h1234_56A7);
        chk(fb_we && fb_index == 17'd5 && fb_data == 8'hA7, "R5 fb write", {fb_we, 6'd0, fb_index, fb_data}, {1'b1, 6'd0, 17'd5, 8'hA7});
        chk(ram_a_we == 4'd0 && ram_b_we == 4'd0, "R5 fb no ram", 32'({ram_a_we, ram_b_we}), 32'h0);
        retire(); idle();
        drive(1'b1, 2'd0, 1'b0, 32'h4001_2BFF, 32'h0000_0033);
        chk(fb_we && fb_index == 17'd76799, "R5 fb last pixel", {15'd0, fb_we, fb_index}, {15'd0, 1'b1, 17'd76799});
        retire(); idle();
        // R6: out-of-range pixel indices dropped
        drive(1'b1, 2'd0, 1'b0, 32'h4001_2C00, 32'h0000_0044);
        chk(!fb_we && ram_a_we == 4'd0 && ram_b_we == 4'd0, "R6 index 76800 dropped", 32'({fb_we, ram_a_we, ram_b_we}), 32'h0);
        retire(); idle();
        drive(1'b1, 2'd2, 1'b0, 32'h4AFF_FFFF, 32'h0000_0055);
        chk(!fb_we, "R6 window end dropped", 32'(fb_we), 32'h0);
        retire(); idle();
        // R7: framebuffer read returns zero
        drive(1'b0, 2'd2, 1'b0, 32'h4000_0010, 32'h0);
        retire();
        chk(rsp_valid && rsp_rdata == 32'h0, "R7 fb read zero", rsp_rdata, 32'h0);
        idle();

        // R8: buttons
        btn_in = 4'b1010;
        drive(1'b0, 2'd2, 1'b0, 32'h4B00_0000, 32'h0);
        retire();
        btn_in = 4'b0101;
        chk(rsp_valid && rsp_rdata == 32'h0000_000A, "R8 buttons word", rsp_rdata, 32'h0000_000A);
        idle();
        btn_in = 4'b1111;
        drive(1'b0, 2'd0, 1'b0, 32'h4B00_0000, 32'h0);
        retire();
        chk(rsp_rdata == 32'h0000_000F, "R8 buttons byte", rsp_rdata, 32'h0000_000F);
        idle();

        // R9: store to button address ignored
        drive(1'b1, 2'd2, 1'b0, 32'h4B00_0000, 32'hDEAD_BEEF);
        chk(!fb_we && ram_a_we == 4'd0 && ram_b_we == 4'd0, "R9 button store strobes", 32'({fb_we, ram_a_we, ram_b_we}), 32'h0);
        retire(); idle();
        drive(1'b0, 2'd2, 1'b0, 32'h0000_0000, 32'h0);
        retire();
        chk(rsp_rdata == 32'h4433_1234, "R9 ram unchanged", rsp_rdata, 32'h4433_1234);
        idle();

        // R11: store via alias, read back at base address
        drive(1'b1, 2'd0, 1'b0, 32'h0000_3002, 32'h0000_00EE);
        retire(); idle();
        drive(1'b0, 2'd2, 1'b0, 32'h0000_0000, 32'h0);
        retire();
        chk(rsp_rdata == 32'h44EE_1234, "R11 alias store", rsp_rdata, 32'h44EE_1234);
        idle();

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule